// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer / Event Counter

This block is an 8-bit up-counter for a small controller. It has three counting modes. In event mode it counts edges on an external pin. In timer mode it counts pulses of an internal tick. In pulse mode it measures one high or one low interval of the external pin. Software reaches it through two register locations, selected by `wr_sel`. The data location holds two physical registers: a write loads a reload value, and the read port always shows the live count. The control location holds the mode, a run enable and an edge choice.

When the count steps past its top value, the counter takes the reload value and raises a sticky interrupt flag. A divider output also toggles on each such step. With a reload value N and the tick present in every cycle, the divider output has a frequency of tick/(2·(256−N)).

Register writes take a single cycle, so the block never pushes back on the writer. There is no valid/ready stream at its edge, and all pins are plain control and status signals.

Top module: `cnt8_timer`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x08, `data_rd` reads 0, and both `irq_flag` and `div_out` are 0.
- R2: A write with `wr_sel`=0 changes only the reload value. `data_rd` always shows the live count, and the write leaves it untouched.
- R3: The control layout is: bits 7:6 select the mode (00 halted, 01 event, 10 timer, 11 pulse), bit 5 is the run enable, and bit 3 is the edge choice. Bits 4 and 2:0 always read 0. The count holds while the mode is 00 or the enable is 0.
- R4: In timer mode with the enable set, the count rises by one on each clock where `int_tick` is 1, and holds on clocks where it is 0.
- R5: In event mode with the enable set, the count rises by one for each synchronized edge of `ext_pin`. It counts rising edges when bit 3 is 1 and falling edges when bit 3 is 0, whatever `int_tick` does.
- R6: In every mode, a step taken from 0xFF loads the reload value into the counter and sets `irq_flag` at the same clock edge.
- R7: `irq_flag` stays at 1 until `irq_clr` clears it. If the clear and an overflow fall on the same edge, the flag stays set.
- R8: `div_out` toggles once per overflow. With the tick always high and reload N, two toggles are 256−N clocks apart.
- R9: In pulse mode with the enable set, the measurement starts on a rising edge when bit 3 is 1, or on a falling edge when bit 3 is 0. From the starting edge on, the count rises on each tick while the pin stays at the new level, and the starting cycle itself is counted.
- R10: When the pin returns to its first level, the hardware clears the enable (bit 5) and keeps the count. Later pin transitions leave the count unchanged until software sets the enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_tick | input | 1 | Internal count tick, one cycle per pulse |
| ext_pin | input | 1 | Asynchronous external input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = data/reload location, 1 = control |
| wr_data | input | 8 | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| data_rd | output | 8 | Live count |
| ctrl_rd | output | 8 | Control register readback |
| irq_flag | output | 1 | Sticky overflow flag |
| div_out | output | 1 | Divider output, toggles on each overflow |

## Verification
The bench places a flag clear on the same edge as an overflow. A design that lets the clear win would lose that interrupt. A scoreboard measures the spacing of divider toggles for three reload values, including 0. A design that reloads one cycle late, or from the wrong value, would show a shifted period. Pulse mode is tested with both edge choices, and a second pulse follows each measurement. A design that failed to clear its own enable would count that pulse too, and one that skipped the starting cycle would read short by one.

// File: rtl/cnt8_pkg.sv
package cnt8_pkg;
  typedef enum logic [1:0] {
    MODE_HALT  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmode_e;

  typedef enum logic {
    PW_WAIT = 1'b0,
    PW_MEAS = 1'b1
  } pw_state_e;

  localparam int CTRL_W     = 8;
  localparam int CTL_MODE_HI = 7;
  localparam int CTL_MODE_LO = 6;
  localparam int CTL_RUN     = 5;
  localparam int CTL_EDGE    = 3;
endpackage

// File: rtl/cnt8_pin_sync.sv
module cnt8_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], pin_i};
  end

  assign level_o = chain_q[LAST-1];
  assign rise_o  = chain_q[LAST-1] & ~chain_q[LAST];
  assign fall_o  = ~chain_q[LAST-1] & chain_q[LAST];
endmodule

// File: rtl/cnt8_pw_fsm.sv
module cnt8_pw_fsm
  import cnt8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic edge_hi_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic tick_i,
  output logic step_o,
  output logic done_o
);
  pw_state_e st_q, st_d;
  logic start_w, stop_w;

  assign start_w = edge_hi_i ? rise_i : fall_i;
  assign stop_w  = edge_hi_i ? fall_i : rise_i;

  always_comb begin
    st_d   = st_q;
    done_o = 1'b0;
    if (!armed_i) begin
      st_d = PW_WAIT;
    end else begin
      case (st_q)
        PW_WAIT: if (start_w) st_d = PW_MEAS;
        PW_MEAS: if (stop_w) begin
          st_d   = PW_WAIT;
          done_o = 1'b1;
        end
        default: st_d = PW_WAIT;
      endcase
    end
  end

  assign step_o = armed_i && tick_i &&
                  (((st_q == PW_WAIT) && start_w) || ((st_q == PW_MEAS) && !stop_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PW_WAIT;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/cnt8_core.sv
module cnt8_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         pre_wr_i,
  input  logic [W-1:0] pre_data_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] preload_o,
  output logic         ovf_o,
  output logic         flag_o,
  output logic         div_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, pre_q;
  logic         flag_q, div_q;

  assign ovf_o = step_i && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      flag_q <= 1'b0;
      div_q  <= 1'b0;
    end else begin
      if (pre_wr_i) pre_q <= pre_data_i;
      if (ovf_o)       cnt_q <= pre_q;
      else if (step_i) cnt_q <= cnt_q + 1'b1;
      if (ovf_o)       flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
      if (ovf_o) div_q <= ~div_q;
    end
  end

  assign count_o   = cnt_q;
  assign preload_o = pre_q;
  assign flag_o    = flag_q;
  assign div_o     = div_q;
endmodule

// File: rtl/cnt8_timer.sv
module cnt8_timer
  import cnt8_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         int_tick,
  input  logic         ext_pin,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [7:0]   wr_data,
  input  logic         irq_clr,
  output logic [W-1:0] data_rd,
  output logic [7:0]   ctrl_rd,
  output logic         irq_flag,
  output logic         div_out
);
  tmode_e mode_q;
  logic   run_q, edge_hi_q;
  logic   pin_lvl, pin_rise, pin_fall;
  logic   pw_step, pw_done, step_w;
  logic   ovf_w;
  logic [W-1:0] preload_w;
  logic   ctl_wr, dat_wr;
  logic   unused_bits;

  assign ctl_wr      = wr_en &&  wr_sel;
  assign dat_wr      = wr_en && !wr_sel;
  assign unused_bits = ^{wr_data[4], wr_data[2:0], pin_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_HALT;
      run_q     <= 1'b0;
      edge_hi_q <= 1'b1;
    end else if (ctl_wr) begin
      mode_q    <= tmode_e'(wr_data[CTL_MODE_HI:CTL_MODE_LO]);
      run_q     <= wr_data[CTL_RUN];
      edge_hi_q <= wr_data[CTL_EDGE];
    end else if (pw_done) begin
      run_q <= 1'b0;
    end
  end

  assign ctrl_rd = {mode_q, run_q, 1'b0, edge_hi_q, 3'b000};

  cnt8_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin),
    .level_o(pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  cnt8_pw_fsm pw_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed_i  (run_q && (mode_q == MODE_PULSE)),
    .edge_hi_i(edge_hi_q),
    .rise_i   (pin_rise),
    .fall_i   (pin_fall),
    .tick_i   (int_tick),
    .step_o   (pw_step),
    .done_o   (pw_done)
  );

  always_comb begin
    step_w = 1'b0;
    if (run_q) begin
      case (mode_q)
        MODE_EVENT: step_w = edge_hi_q ? pin_rise : pin_fall;
        MODE_TIMER: step_w = int_tick;
        MODE_PULSE: step_w = pw_step;
        default:    step_w = 1'b0;
      endcase
    end
  end

  cnt8_core #(.W(W)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_w),
    .pre_wr_i  (dat_wr),
    .pre_data_i(wr_data[W-1:0]),
    .clr_i     (irq_clr),
    .count_o   (data_rd),
    .preload_o (preload_w),
    .ovf_o     (ovf_w),
    .flag_o    (irq_flag),
    .div_o     (div_out)
  );
endmodule

// File: rtl/cnt8_timer_chk.sv
module cnt8_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         int_tick,
  input logic         wr_en,
  input logic         wr_sel,
  input logic         irq_clr,
  input logic [W-1:0] data_rd,
  input logic [7:0]   ctrl_rd,
  input logic         irq_flag,
  input logic         div_out,
  input logic         ovf,
  input logic [W-1:0] preload
);
  localparam logic [W-1:0] TOP = '1;

  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[5] |=> $stable(data_rd));

  a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[7:5] == 3'b101) && int_tick && (data_rd != TOP)
    |=> data_rd == W'($past(data_rd) + 1'b1));

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (data_rd == $past(preload)) && irq_flag);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && irq_clr && !ovf |=> !irq_flag);

  a_r8_div_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (div_out != $past(div_out)) |-> irq_flag);

  a_r10_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rd[5]) && !$past(wr_en && wr_sel) |-> ctrl_rd[7:6] == 2'b11);
endmodule

bind cnt8_timer cnt8_timer_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .int_tick(int_tick),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .irq_clr (irq_clr),
  .data_rd (data_rd),
  .ctrl_rd (ctrl_rd),
  .irq_flag(irq_flag),
  .div_out (div_out),
  .ovf     (ovf_w),
  .preload (preload_w)
);

// File: tb/cnt8_timer_tb_top.sv
`timescale 1ns/1ps
module cnt8_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_tick = 1'b1;
  logic       ext_pin = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_clr = 1'b0;
  logic [7:0] data_rd, ctrl_rd;
  logic       irq_flag, div_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  cnt8_timer dut_i (
    .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_pin(ext_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr),
    .data_rd(data_rd), .ctrl_rd(ctrl_rd), .irq_flag(irq_flag), .div_out(div_out)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(bit sel, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pin_pulses(int n, int half);
    for (int i = 0; i < n; i++) begin
      ext_pin = ~ext_pin; cycles(half);
      ext_pin = ~ext_pin; cycles(half);
    end
  endtask

  // Monitor: measures divider toggle spacing against queued expectations (R8)
  initial begin
    int last_tog = 0;
    logic prev = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (div_out !== prev) begin
        if (exp_q.size() > 0) chk("R8 divider interval", cyc - last_tog, exp_q.pop_front());
        last_tog = cyc;
        prev = div_out;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    int nvals[3] = '{8'hF0, 8'h80, 8'h00};
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    chk("R1 ctrl reset", ctrl_rd, 8'h08);
    chk("R1 count reset", data_rd, 0);
    chk("R1 flag reset", irq_flag, 0);
    chk("R1 div reset", div_out, 0);

    reg_wr(1'b0, 8'h40);
    cycles(2);
    chk("R2 preload write leaves count", data_rd, 0);

    reg_wr(1'b1, 8'h3F);
    chk("R3 unimplemented bits read 0", ctrl_rd, 8'h28);
    cycles(8);
    chk("R3 halted mode holds", data_rd, 0);

    // timer mode: 10,run,0,edge1
    reg_wr(1'b1, 8'hA8);
    c0 = data_rd;
    cycles(10);
    chk("R4 timer counts ticks", data_rd, c0 + 10);
    int_tick = 1'b0;
    c0 = data_rd;
    cycles(5);
    chk("R4 no tick no count", data_rd, c0);
    int_tick = 1'b1;

    reg_wr(1'b0, 8'hF0);
    forever begin @(posedge clk); #1; if (irq_flag) break; end
    chk("R6 reload on overflow", data_rd, 8'hF0);
    cycles(5);
    chk("R7 flag sticky", irq_flag, 1);
    forever begin @(posedge clk); #1; if (data_rd == 8'hFF) break; end
    irq_clr = 1'b1;
    cycles(1);
    chk("R7 overflow beats clear", irq_flag, 1);
    chk("R6 second reload", data_rd, 8'hF0);
    cycles(1);
    irq_clr = 1'b0;
    chk("R7 clear works", irq_flag, 0);

    foreach (nvals[k]) begin
      reg_wr(1'b0, 8'(nvals[k]));
      @(div_out); #3;
      for (int j = 0; j < 3; j++) exp_q.push_back(256 - nvals[k]);
      wait (exp_q.size() == 0);
      cycles(1);
    end

    // event mode, rising edges, tick ignored
    int_tick = 1'b0;
    reg_wr(1'b1, 8'h68);
    cycles(3);
    c0 = data_rd;
    pin_pulses(5, 3);
    cycles(4);
    chk("R5 rising edges counted", data_rd, (c0 + 5) % 256);
    reg_wr(1'b1, 8'h60);
    cycles(3);
    c0 = data_rd;
    pin_pulses(3, 3);
    cycles(4);
    chk("R5 falling edges counted", data_rd, (c0 + 3) % 256);

    // pulse mode, high interval
    int_tick = 1'b1;
    ext_pin = 1'b0;
    reg_wr(1'b1, 8'hE8);
    cycles(3);
    c0 = data_rd;
    ext_pin = 1'b1; cycles(20); ext_pin = 1'b0;
    cycles(6);
    chk("R9 high pulse width", data_rd, (c0 + 20) % 256);
    chk("R10 enable self-cleared", ctrl_rd, 8'hC8);
    c0 = data_rd;
    ext_pin = 1'b1; cycles(10); ext_pin = 1'b0;
    cycles(6);
    chk("R10 second pulse ignored", data_rd, c0);

    // pulse mode, low interval
    ext_pin = 1'b1;
    cycles(4);
    reg_wr(1'b1, 8'hE0);
    cycles(3);
    c0 = data_rd;
    ext_pin = 1'b0; cycles(15); ext_pin = 1'b1;
    cycles(6);
    chk("R9 low pulse width", data_rd, (c0 + 15) % 256);
    chk("R10 enable self-cleared low", ctrl_rd, 8'hC0);
    c0 = data_rd;
    ext_pin = 1'b0; cycles(7); ext_pin = 1'b1;
    cycles(6);
    chk("R10 later low pulse ignored", data_rd, c0);

    done = 1;
    summary();
    $finish;
  end
endmodule